// File: doc/BRIEF.md
# Fuse Array Strobe Read Port

This block gives software a register-level window onto a one-time-programmable fuse array. Rather than running an automatic read engine, it exposes the array's macro pins as bits of a control register. Software places the array in read mode by setting the load bit and keeping the program enable inactive. It then puts an address into the address field, raises the strobe, and picks up the selected fuse data from a data-out register. Each address is read with its own strobe pulse. When the transfer is over, software writes the standby encoding back.

Two organisations are built from the same source, chosen by the `WORD_MODE` parameter. Byte mode returns one 8-bit fuse byte per strobe. Word mode returns a 32-bit fuse word per strobe and adds a power-down pin. The array contents are fixed at build time and derived from a seed parameter. In this model the array can never be written.

Top module: `fuse_read_port`

## Requirements
- R1: After a synchronous reset (rstN low at a clock edge) the control register reads 0x00000009 in byte mode (chip select off, program enable off) and 0x00000021 in word mode (chip select off, power-down on). The data-out register reads 0.
- R2: The control register is at bus offset 0x0 and holds all 32 written bits on read-back. Data-out at offset 0x4 is read-only, so writes to it have no effect. Any other offset reads 0.
- R3: Control bit 0 is the active-low chip select, bit 1 the strobe, bit 2 load, bit 3 the active-low program enable, and bit 5 power-down (word mode only). A strobe rising edge captures the array entry at the current address field into data-out, provided chip select is low, load is high and, in word mode, power-down is low. A rising edge means a control write that changes bit 1 from 0 to 1. The new value is readable from the second clock edge after that write.
- R4: Data-out keeps its captured value until the next qualifying strobe rising edge. Lowering the strobe or changing the address does not change it.
- R5: While chip select is high, or power-down is high in word mode, data-out reads 0 and strobe rising edges capture nothing. Once the block is selected again, the value held from earlier reappears.
- R6: In byte mode the fuse address is control bits 15:6. The data is in data-out bits 7:0, and bits 31:8 read 0.
- R7: In word mode the fuse address is control bits 25:16, and data-out returns all 32 bits.
- R8: The address is 10 bits wide. Control bits outside the active address field and outside the pin bits have no effect on which entry is read.
- R9: The array entry at address a is the low 32 bits of (a × 0x9E3779B1) XOR FUSE_SEED. Byte mode uses the low 8 bits of that entry.
- R10: A strobe with program enable asserted (bit 3 low) and load low captures nothing. The array contents are left unchanged, so a later normal read of that address returns the R9 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| busWrite | input | 1 | Register write enable for this cycle |
| busAddr | input | BUS_AW | Register byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for busAddr |

## Verification
The bench builds two copies side by side: one with `WORD_MODE` = 0 and one with `WORD_MODE` = 1, both using the default seed. With the byte copy it exercises the 15:6 address field, the zero upper data bits, and gating by chip select alone. With the word copy it exercises the 25:16 field, full 32-bit data and gating by power-down. Having both in one run shows that each copy ignores the other's address field.

// File: rtl/fuse_port_pkg.sv
package fuse_port_pkg;
  localparam int FUSE_AW = 10;
  localparam int REG_W = 32;
  localparam int CTRL_OFS = 0;
  localparam int DOUT_OFS = 4;
  localparam int CS_N_BIT = 0;
  localparam int STROBE_BIT = 1;
  localparam int LOAD_BIT = 2;
  localparam int PGM_N_BIT = 3;
  localparam int PWRDN_BIT = 5;
  localparam int RDSEL_BIT = 7;
  localparam int SHIFTSEL_BIT = 9;
  localparam int BYTE_ADDR_LSB = 6;
  localparam int WORD_ADDR_LSB = 16;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic gateOff;
    logic [FUSE_AW-1:0] fuseAddr;
  } fuseCmd_t;

  function automatic logic [REG_W-1:0] fuseContent(input logic [FUSE_AW-1:0] addr,
                                                    input logic [REG_W-1:0] seed);
    logic [REG_W-1:0] prod;
    prod = REG_W'(addr) * 32'h9E3779B1;
    return prod ^ seed;
  endfunction
endpackage

// File: rtl/fuse_port_ctrl.sv
module fuse_port_ctrl
  import fuse_port_pkg::*;
#(
  parameter bit WORD_MODE = 1'b0,
  parameter int BUS_AW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  ctrlQ,
  output fuseCmd_t          cmd
);
  localparam logic [REG_W-1:0] STANDBY = WORD_MODE ?
    ((REG_W'(1) << CS_N_BIT) | (REG_W'(1) << PWRDN_BIT)) :
    ((REG_W'(1) << CS_N_BIT) | (REG_W'(1) << PGM_N_BIT));
  localparam int ADDR_LSB = WORD_MODE ? WORD_ADDR_LSB : BYTE_ADDR_LSB;

  logic prevStrobe;
  logic gateOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= STANDBY;
      prevStrobe <= 1'b0;
    end else begin
      if (busWrite && busAddr == BUS_AW'(CTRL_OFS)) ctrlQ <= busWdata;
      prevStrobe <= ctrlQ[STROBE_BIT];
    end
  end

  generate
    if (WORD_MODE) begin : g_word
      assign gateOff = ctrlQ[CS_N_BIT] | ctrlQ[PWRDN_BIT];
    end else begin : g_byte
      assign gateOff = ctrlQ[CS_N_BIT];
    end
  endgenerate

  always_comb begin
    cmd.gateOff = gateOff;
    cmd.capture = ctrlQ[STROBE_BIT] & ~prevStrobe & ~gateOff & ctrlQ[LOAD_BIT];
    cmd.fuseAddr = ctrlQ[ADDR_LSB +: FUSE_AW];
  end
endmodule

// File: rtl/fuse_port_datapath.sv
module fuse_port_datapath
  import fuse_port_pkg::*;
#(
  parameter bit WORD_MODE = 1'b0,
  parameter logic [31:0] FUSE_SEED = 32'h5A5AC3C3
) (
  input  logic             clk,
  input  logic             rstN,
  input  fuseCmd_t         cmd,
  output logic [REG_W-1:0] doutHeld,
  output logic [REG_W-1:0] doutView
);
  logic [REG_W-1:0] cellRaw;
  logic [REG_W-1:0] cellSized;

  assign cellRaw = fuseContent(cmd.fuseAddr, FUSE_SEED);

  generate
    if (WORD_MODE) begin : g_word
      assign cellSized = cellRaw;
    end else begin : g_byte
      assign cellSized = {{(REG_W-8){1'b0}}, cellRaw[7:0]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) doutHeld <= '0;
    else if (cmd.capture) doutHeld <= cellSized;
  end

  assign doutView = cmd.gateOff ? '0 : doutHeld;
endmodule

// File: rtl/fuse_read_port.sv
module fuse_read_port
  import fuse_port_pkg::*;
#(
  parameter bit WORD_MODE = 1'b0,
  parameter logic [31:0] FUSE_SEED = 32'h5A5AC3C3,
  parameter int BUS_AW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata
);
  logic [REG_W-1:0] ctrlQ;
  logic [REG_W-1:0] doutHeld;
  logic [REG_W-1:0] doutView;
  fuseCmd_t cmd;

  fuse_port_ctrl #(.WORD_MODE(WORD_MODE), .BUS_AW(BUS_AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .ctrlQ(ctrlQ), .cmd(cmd)
  );

  fuse_port_datapath #(.WORD_MODE(WORD_MODE), .FUSE_SEED(FUSE_SEED)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .doutHeld(doutHeld), .doutView(doutView)
  );

  always_comb begin
    if (busAddr == BUS_AW'(CTRL_OFS)) busRdata = ctrlQ;
    else if (busAddr == BUS_AW'(DOUT_OFS)) busRdata = doutView;
    else busRdata = '0;
  end
endmodule

// File: rtl/fuse_read_port_chk.sv
module fuse_read_port_chk #(
  parameter bit WORD_MODE = 1'b0,
  parameter int BUS_AW = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrite,
  input logic [BUS_AW-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic [31:0]       ctrlQ,
  input logic              capture,
  input logic [31:0]       doutHeld
);
  a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == BUS_AW'(0)) |=> ctrlQ == $past(busWdata));

  a_r3_capture_qualified: assert property (@(posedge clk) disable iff (!rstN)
    capture |-> (!ctrlQ[0] && ctrlQ[2] && ctrlQ[1] && !$past(ctrlQ[1])));

  a_r4_hold_between_strobes: assert property (@(posedge clk) disable iff (!rstN)
    !capture |=> $stable(doutHeld));

  a_r5_gated_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == BUS_AW'(4) && (ctrlQ[0] || (WORD_MODE && ctrlQ[5]))) |-> busRdata == 32'd0);

  a_r6_byte_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!WORD_MODE && busAddr == BUS_AW'(4)) |-> busRdata[31:8] == 24'd0);

  a_r10_no_capture_unloaded: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ[2] |-> !capture);
endmodule

bind fuse_read_port fuse_read_port_chk #(.WORD_MODE(WORD_MODE), .BUS_AW(BUS_AW)) u_chk (
  .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
  .busRdata(busRdata), .ctrlQ(ctrlQ), .capture(cmd.capture), .doutHeld(doutHeld)
);

// File: tb/test_fuse_read_port.sv
`timescale 1ns/1ps
module test_fuse_read_port;
  localparam logic [31:0] SEED = 32'h5A5AC3C3;
  localparam logic [31:0] CS_N = 32'h1, STB = 32'h2, LOAD = 32'h4, PGM_N = 32'h8;
  localparam logic [31:0] PD = 32'h20, RDSEL = 32'h80, SHSEL = 32'h200;
  // stimulus: {mode, fuse address}; expected value computed from R9
  localparam logic [10:0] VEC [8] = '{
    {1'b0, 10'd0}, {1'b0, 10'd1}, {1'b0, 10'h3FF}, {1'b0, 10'h155},
    {1'b1, 10'd0}, {1'b1, 10'd7}, {1'b1, 10'h3FF}, {1'b1, 10'h2AA}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wr [2];
  logic [3:0] ad [2];
  logic [31:0] wd [2];
  logic [31:0] rd [2];
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fuse_read_port #(.WORD_MODE(1'b0)) i_fuse_read_port (
    .clk(clk), .rstN(rstN), .busWrite(wr[0]), .busAddr(ad[0]), .busWdata(wd[0]), .busRdata(rd[0]));
  fuse_read_port #(.WORD_MODE(1'b1)) i_fuse_read_port_w (
    .clk(clk), .rstN(rstN), .busWrite(wr[1]), .busAddr(ad[1]), .busWdata(wd[1]), .busRdata(rd[1]));

  function automatic logic [31:0] expData(input int m, input logic [9:0] a);
    logic [31:0] v;
    v = ({22'd0, a} * 32'h9E3779B1) ^ SEED;
    return m ? v : {24'd0, v[7:0]};
  endfunction

  function automatic logic [31:0] addrField(input int m, input logic [9:0] a);
    return m ? ({22'd0, a} << 16) : ({22'd0, a} << 6);
  endfunction

  function automatic logic [31:0] readBase(input int m);
    return m ? (LOAD | PGM_N | RDSEL | SHSEL) : (LOAD | PGM_N);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrReg(input int m, input logic [3:0] ofs, input logic [31:0] d);
    @(negedge clk);
    wr[m] = 1'b1; ad[m] = ofs; wd[m] = d;
    @(negedge clk);
    wr[m] = 1'b0;
  endtask

  task automatic rdReg(input int m, input logic [3:0] ofs, output logic [31:0] v);
    ad[m] = ofs;
    #1;
    v = rd[m];
  endtask

  task automatic fuseRead(input int m, input logic [9:0] a, input logic [31:0] extra,
                          output logic [31:0] v);
    logic [31:0] c;
    c = readBase(m) | addrField(m, a) | extra;
    wrReg(m, 4'h0, readBase(m));
    wrReg(m, 4'h0, c);
    wrReg(m, 4'h0, c | STB);
    @(negedge clk);
    rdReg(m, 4'h4, v);
    wrReg(m, 4'h0, c);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, held;
    for (int m = 0; m < 2; m++) begin wr[m] = 0; ad[m] = 0; wd[m] = 0; end
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rdReg(0, 4'h0, v); check("R1 byte ctrl", v, 32'h9);
    rdReg(1, 4'h0, v); check("R1 word ctrl", v, 32'h21);
    rdReg(0, 4'h4, v); check("R1 byte dout", v, 32'h0);
    rdReg(1, 4'h4, v); check("R1 word dout", v, 32'h0);

    // table walk: R3 R6 R7 R9
    for (int i = 0; i < 8; i++) begin
      fuseRead(int'(VEC[i][10]), VEC[i][9:0], 32'h0, v);
      check(VEC[i][10] ? "R3 R7 R9 word read" : "R3 R6 R9 byte read", v,
            expData(int'(VEC[i][10]), VEC[i][9:0]));
    end

    for (int m = 0; m < 2; m++) begin
      // R4 hold after strobe low and address change
      fuseRead(m, 10'd5, 32'h0, v);
      held = expData(m, 10'd5);
      rdReg(m, 4'h4, v); check("R4 hold after strobe low", v, held);
      wrReg(m, 4'h0, readBase(m) | addrField(m, 10'd9));
      @(negedge clk);
      rdReg(m, 4'h4, v); check("R4 hold after address change", v, held);

      // R2 data-out write ignored, other offsets zero, ctrl read-back
      wrReg(m, 4'h4, 32'hFFFFFFFF);
      @(negedge clk);
      rdReg(m, 4'h4, v); check("R2 dout write ignored", v, held);
      rdReg(m, 4'h8, v); check("R2 unmapped offset", v, 32'h0);

      // R5 gating: deselect, strobe ignored, value back on reselect
      wrReg(m, 4'h0, readBase(m) | addrField(m, 10'd9) | (m ? PD : CS_N));
      rdReg(m, 4'h4, v); check("R5 gated dout zero", v, 32'h0);
      wrReg(m, 4'h0, readBase(m) | addrField(m, 10'd9) | (m ? PD : CS_N) | STB);
      @(negedge clk);
      wrReg(m, 4'h0, readBase(m) | addrField(m, 10'd9) | (m ? PD : CS_N));
      wrReg(m, 4'h0, readBase(m) | addrField(m, 10'd9));
      @(negedge clk);
      rdReg(m, 4'h4, v); check("R5 strobe ignored while off", v, held);

      // R8 bits outside address field ignored
      fuseRead(m, 10'd3, m ? 32'h8000FFC0 : 32'h83FF0000, v);
      check("R8 extra bits ignored", v, expData(m, 10'd3));

      // R10 program attempt: pgm enable low, load low, strobe
      fuseRead(m, 10'd4, 32'h0, v);
      wrReg(m, 4'h0, addrField(m, 10'd6));
      wrReg(m, 4'h0, addrField(m, 10'd6) | STB);
      @(negedge clk);
      wrReg(m, 4'h0, addrField(m, 10'd6));
      rdReg(m, 4'h4, v); check("R10 no capture on program attempt", v, expData(m, 10'd4));
      fuseRead(m, 10'd6, 32'h0, v);
      check("R10 contents unchanged", v, expData(m, 10'd6));
    end

    // R2 full 32-bit ctrl read-back
    wrReg(0, 4'h0, 32'hA5A50009);
    rdReg(0, 4'h0, v); check("R2 ctrl read-back", v, 32'hA5A50009);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule